// File: doc/BRIEF.md
# DDS Serial Control Word Loader

This block moves a 40-bit control word into a direct digital synthesizer over a three-wire serial link. The three wires are serial data, a shift clock and a frequency-update strobe. The host presents a word and pulses a start strobe while the loader is idle. The loader captures the word and shifts it out one bit at a time, least significant bit first. Byte 0 therefore leaves first and byte 4 leaves last. It then raises the update strobe once so that the synthesizer applies the new word, and finally drops all three wires low.

All wire timing is counted in time units. One time unit is `CLK_PER_UNIT` clock cycles, set by a parameter. Each bit spends three units on the link:
- one setup unit, with the data valid and the shift clock low;
- one unit with the shift clock high;
- one hold unit, with the shift clock low and the data unchanged.

A whole word, including its update unit, takes `3*WORD_BITS+1` units. On leaving reset the loader sends `INIT_WORDS` all-zero words (two by default) back to back, each with its own update strobe, and only then accepts requests. The busy output is high from a start, or from reset, until the wires are idle again.

Top module: `dds_word_loader`

## Requirements
- R1: On leaving reset, busy_o is high at once and the loader sends two all-zero words back to back, each followed by one update pulse; a start strobe during this period is ignored.
- R2: A start_i high at a rising clock edge while busy_o is low captures word_i, and busy_o is high from the following cycle.
- R3: The k-th rising edge of sclk_o within a word carries bit k of the captured word on sdat_o (k = 0..39), so bit 0 of byte 0 goes first and bit 7 of byte 4 goes last.
- R4: sdat_o is stable for at least one time unit before each rising edge of sclk_o. sclk_o then stays high for exactly one time unit, during which sdat_o does not change. sdat_o then stays unchanged for at least one more time unit after sclk_o falls.
- R5: After the 40th shift-clock pulse, upd_o goes high exactly once, for exactly one time unit, while sclk_o is low.
- R6: When the update pulse ends and no further zero word of the reset sequence is pending, busy_o, sdat_o, sclk_o and upd_o are all low in the same cycle.
- R7: A start_i while busy_o is high has no effect, and changes to word_i after capture do not change the word being sent.
- R8: Whenever busy_o is low, sdat_o, sclk_o and upd_o are all low.
- R9: busy_o stays high for exactly (3*40+1)*CLK_PER_UNIT cycles per word sent. The reset sequence therefore lasts twice that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only while idle |
| word_i | input | 40 | Control word, captured at start |
| busy_o | output | 1 | High while a word is in flight or the reset sequence runs |
| sdat_o | output | 1 | Serial data to the synthesizer |
| sclk_o | output | 1 | Shift clock; the synthesizer samples on its rising edge |
| upd_o | output | 1 | Frequency-update strobe |

## Verification
A wrong bit counter or shift register shows up at the next update pulse. The word rebuilt from the shift-clock edges then differs from the word that was queued, or the pulse count per word is not 40. A phase sequencer or unit timer that slips shows up within one time unit as a high pulse or hold window of the wrong width. A busy window of the wrong length is seen when busy_o falls. A start that leaks through while busy produces an extra update pulse with nothing queued, so the fault is reported by the end of that stray word.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_HIGH   = 3'd2,
    PH_HOLD   = 3'd3,
    PH_UPDATE = 3'd4
  } phase_t;

  typedef struct packed {
    logic busy;
    logic sdat;
    logic sclk;
    logic upd;
  } lines_t;

  // number of time units a single word occupies on the link
  function automatic int unsigned units_per_word(int unsigned bits);
    return 3 * bits + 1;
  endfunction

  // phase that follows the current one at the end of a time unit
  function automatic phase_t phase_after(phase_t cur, logic last_bit, logic more_init);
    phase_t nxt;
    unique case (cur)
      PH_SETUP:  nxt = PH_HIGH;
      PH_HIGH:   nxt = PH_HOLD;
      PH_HOLD:   nxt = last_bit ? PH_UPDATE : PH_SETUP;
      PH_UPDATE: nxt = more_init ? PH_SETUP : PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  // wire levels for a phase and the bit currently at the head of the word
  function automatic lines_t drive_lines(phase_t ph, logic head_bit);
    lines_t l;
    l.busy = (ph != PH_IDLE);
    l.sdat = ((ph == PH_SETUP) || (ph == PH_HIGH) || (ph == PH_HOLD)) && head_bit;
    l.sclk = (ph == PH_HIGH);
    l.upd  = (ph == PH_UPDATE);
    return l;
  endfunction

endpackage

// File: rtl/dds_unit_timer.sv
module dds_unit_timer #(
  parameter int unsigned CLK_PER_UNIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (CLK_PER_UNIT > 1) ? $clog2(CLK_PER_UNIT) : 1;

  generate
    if (CLK_PER_UNIT <= 1) begin : g_every
      assign tick = run;
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_UNIT - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/dds_word_shifter.sv
module dds_word_shifter #(
  parameter int unsigned WORD_BITS = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] load_word,
  input  logic                 shift,
  output logic                 head_bit,
  output logic                 last_bit
);
  localparam int unsigned CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_BITS - 1);

  logic [WORD_BITS-1:0] shreg;
  logic [CW-1:0]        bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
    end else if (load) begin
      shreg   <= load_word;
      bit_idx <= '0;
    end else if (shift) begin
      shreg   <= {1'b0, shreg[WORD_BITS-1:1]};
      bit_idx <= (bit_idx == LAST_IDX) ? '0 : bit_idx + 1'b1;
    end
  end

  assign head_bit = shreg[0];
  assign last_bit = (bit_idx == LAST_IDX);
endmodule

// File: rtl/dds_phase_fsm.sv
module dds_phase_fsm
  import dds_ldr_pkg::*;
#(
  parameter int unsigned INIT_WORDS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   tick,
  input  logic   last_bit,
  output phase_t phase,
  output logic   accept,
  output logic   shift_en
);
  localparam int unsigned IW = (INIT_WORDS > 0) ? $clog2(INIT_WORDS + 1) : 1;
  localparam phase_t RESET_PH = (INIT_WORDS > 0) ? PH_SETUP : PH_IDLE;

  logic [IW-1:0] init_left;
  logic          more_init;

  assign accept    = (phase == PH_IDLE) && start;
  assign shift_en  = tick && (phase == PH_HOLD);
  assign more_init = (init_left > IW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= RESET_PH;
      init_left <= IW'(INIT_WORDS);
    end else if (accept) begin
      phase <= PH_SETUP;
    end else if (tick) begin
      phase <= phase_after(phase, last_bit, more_init);
      if ((phase == PH_UPDATE) && (init_left != '0))
        init_left <= init_left - 1'b1;
    end
  end
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_ldr_pkg::*;
#(
  parameter int unsigned WORD_BITS    = 40,
  parameter int unsigned CLK_PER_UNIT = 4,
  parameter int unsigned INIT_WORDS   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [WORD_BITS-1:0] word_i,
  output logic                 busy_o,
  output logic                 sdat_o,
  output logic                 sclk_o,
  output logic                 upd_o
);
  phase_t phase;
  logic   tick;
  logic   accept;
  logic   shift_en;
  logic   head_bit;
  logic   last_bit;
  logic   run;
  lines_t lines;

  assign run = (phase != PH_IDLE);

  dds_unit_timer #(.CLK_PER_UNIT(CLK_PER_UNIT)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  dds_word_shifter #(.WORD_BITS(WORD_BITS)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (word_i),
    .shift     (shift_en),
    .head_bit  (head_bit),
    .last_bit  (last_bit)
  );

  dds_phase_fsm #(.INIT_WORDS(INIT_WORDS)) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .tick     (tick),
    .last_bit (last_bit),
    .phase    (phase),
    .accept   (accept),
    .shift_en (shift_en)
  );

  assign lines  = drive_lines(phase, head_bit);
  assign busy_o = lines.busy;
  assign sdat_o = lines.sdat;
  assign sclk_o = lines.sclk;
  assign upd_o  = lines.upd;
endmodule

// File: rtl/dds_loader_checker.sv
module dds_loader_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic sdat_o,
  input logic sclk_o,
  input logic upd_o,
  input logic accept,
  input logic tick,
  input logic shift_en
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sdat_o && !sclk_o && !upd_o));

  assert_setup_before_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(sdat_o));

  assert_hold_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> $stable(sdat_o));

  assert_shift_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> tick);

  assert_no_clock_during_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_o && upd_o));

  assert_start_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  assert_ignore_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !accept);
endmodule

bind dds_word_loader dds_loader_checker i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .sdat_o   (sdat_o),
  .sclk_o   (sclk_o),
  .upd_o    (upd_o),
  .accept   (accept),
  .tick     (tick),
  .shift_en (shift_en)
);

// File: tb/test_dds_word_loader.sv
`timescale 1ns/1ps
module test_dds_word_loader;
  localparam int WB    = 40;
  localparam int DIV   = 3;
  localparam int UNITS = 3 * WB + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [WB-1:0] word_i;
  logic          busy_o, sdat_o, sclk_o, upd_o;

  int vectors = 0;
  int errs    = 0;
  logic [WB-1:0] expq[$];

  always #10 clk = ~clk;

  dds_word_loader #(.WORD_BITS(WB), .CLK_PER_UNIT(DIV), .INIT_WORDS(2)) i_dds_word_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
    .busy_o(busy_o), .sdat_o(sdat_o), .sclk_o(sclk_o), .upd_o(upd_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: rebuilds words from shift-clock rising edges
  logic          prev_s = 0, prev_w = 0, prev_f = 0, prev_b = 0;
  logic [WB-1:0] cur = '0;
  int nbits = 0, setup_cnt = 0, hi_cnt = 0, fall_age = 0, upd_cnt = 0;
  int busy_len = 0, words_in_busy = 0;
  logic hi_data = 0, hi_bad = 0, hold_armed = 0;
  logic [WB-1:0] expw;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (!busy_o)
        chk(!sdat_o && !sclk_o && !upd_o, "R8 lines low while idle", {sdat_o, sclk_o, upd_o}, 0);
      if (busy_o) busy_len++;
      if (!busy_o && prev_b) begin
        chk(busy_len == words_in_busy * UNITS * DIV, "R9 busy length", busy_len, words_in_busy * UNITS * DIV);
        busy_len = 0;
        words_in_busy = 0;
      end
      if (sclk_o && !prev_w) begin
        chk(setup_cnt >= DIV, "R4 setup before rise", setup_cnt, DIV);
        if (nbits < WB) cur[nbits] = sdat_o;
        nbits++;
        hi_cnt = 0;
        hi_bad = 0;
        hi_data = sdat_o;
        hold_armed = 0;
      end
      if (sclk_o) begin
        hi_cnt++;
        if (sdat_o != hi_data) hi_bad = 1;
      end
      if (!sclk_o && prev_w) begin
        chk(hi_cnt == DIV && !hi_bad, "R4 clock high width and data stable", hi_cnt, DIV);
        hold_armed = 1;
        fall_age = 0;
      end
      if (!sclk_o) begin
        if (hold_armed && (sdat_o != prev_s)) begin
          chk(fall_age >= DIV, "R4 hold after fall", fall_age, DIV);
          hold_armed = 0;
        end
        fall_age++;
        if (prev_w || (sdat_o != prev_s)) setup_cnt = 1;
        else setup_cnt++;
      end
      if (upd_o && !prev_f) begin
        words_in_busy++;
        chk(nbits == WB, "R5 bit count before update", nbits, WB);
        chk(!sclk_o, "R5 shift clock low at update", sclk_o, 0);
        if (expq.size() == 0) begin
          chk(0, "R7 update with no word queued", cur, 0);
        end else begin
          expw = expq.pop_front();
          chk(cur == expw, "R3 rebuilt word", cur, expw);
        end
        nbits = 0;
        cur = '0;
        upd_cnt = 0;
        hold_armed = 0;
      end
      if (upd_o) upd_cnt++;
      if (!upd_o && prev_f) begin
        chk(upd_cnt == DIV, "R5 update width", upd_cnt, DIV);
        if (expq.size() == 0)
          chk(!busy_o && !sdat_o && !sclk_o, "R6 idle after update", {busy_o, sdat_o, sclk_o}, 0);
      end
      prev_s = sdat_o;
      prev_w = sclk_o;
      prev_f = upd_o;
      prev_b = busy_o;
    end
  end

  task automatic send(input logic [WB-1:0] w);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    start_i = 1'b1;
    word_i  = w;
    expq.push_back(w);
    @(negedge clk);
    start_i = 1'b0;
    word_i  = ~w;
    chk(busy_o, "R2 busy after start", busy_o, 1);
    repeat (17) @(negedge clk);
    start_i = 1'b1;          // R7: ignored while busy
    word_i  = w ^ 40'h1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    word_i  = '0;
    expq.push_back('0);
    expq.push_back('0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o, "R1 busy right after reset", busy_o, 1);
    chk(!sclk_o && !upd_o, "R1 clock and update low at reset", {sclk_o, upd_o}, 0);
    repeat (30) @(negedge clk);
    start_i = 1'b1;          // R1: ignored during the zero-word sequence
    word_i  = 40'hDE_ADBE_EF01;
    @(negedge clk);
    start_i = 1'b0;

    send(40'hA5_5AC3_3C96);
    send(40'hFF_FFFF_FFFF);
    send(40'h01_0000_0001);
    send(40'h80_0000_0000);
    send(40'h12_3456_789A);
    send(40'h00_0000_0000);

    @(negedge clk);
    while (busy_o || expq.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R7 no words left over", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired R9 actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule